// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Tracker

This block keeps one atomic-sequence reservation for each CPU of a small multiprocessor and decides, in the cycle a store-conditional is presented, whether that store may go ahead. A load-locked records the cache line it read. Any committed store from any CPU to that line breaks the reservation. An exception or a return from privileged mode on the owning CPU also breaks it.

A store-conditional succeeds only while its CPU still holds a reservation on the same line. On success the block raises the memory write enable for the store, and the result bit that goes to the destination register is 1. On failure both are 0. Either way the reservation is used up. Memory and caches lie outside the block. Stores reach it as a single committed-store broadcast, one per cycle.

Top module: `llsc_rsv_tracker`

## Requirements
- R1: After reset no CPU holds a reservation, so any store-conditional fails.
- R2: A load-locked followed by a store-conditional from the same CPU to the same 64-byte line (address bits 63:6 equal) gives sc_ok_o=1 and sc_wen_o=1 in the cycle sc_req_i is high.
- R3: Lines are compared on address bits 63:6 only. A different byte within the line still matches, and an address in the next line fails.
- R4: A store-conditional consumes its CPU's reservation whether it succeeds or fails, so a second one without a new load-locked fails.
- R5: A later load-locked on the same CPU replaces the recorded line. Only the newest line can succeed.
- R6: A committed store (st_commit_i) breaks the reservation of every CPU holding the same line. Reservations on other lines are kept.
- R7: A committed store and a store-conditional to the same line in the same cycle make the store-conditional fail.
- R8: rsv_clr_i[i] (exception or privileged return) clears only CPU i's reservation. It wins over a load-locked in the same cycle and fails a store-conditional in the same cycle.
- R9: sc_ok_o[i] and sc_wen_o[i] are 0 whenever sc_req_i[i] is 0 or the store-conditional fails.
- R10: A load-locked in the same cycle as a committed store to its line sets no reservation. A load-locked together with a store-conditional on one CPU checks the old reservation and then records the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ll_req_i | input | N_CPU | Load-locked request per CPU |
| ll_addr_i | input | N_CPU x ADDR_W | Load-locked address per CPU |
| sc_req_i | input | N_CPU | Store-conditional check per CPU |
| sc_addr_i | input | N_CPU x ADDR_W | Store-conditional address per CPU |
| st_commit_i | input | 1 | A store from any CPU commits this cycle |
| st_addr_i | input | ADDR_W | Address of the committed store |
| rsv_clr_i | input | N_CPU | Exception or privileged-return clear per CPU |
| sc_ok_o | output | N_CPU | Store-conditional result bit for the destination register |
| sc_wen_o | output | N_CPU | Write enable gate for the store-conditional's memory write |

## Verification
The outputs are combinational on the stored reservation, so a wrong valid bit or line tag shows at the ports in the first store-conditional that probes it. That is the cycle after the corrupting event at the earliest. A reservation that is dropped too readily shows up as a missing success. One that survives a break, a clear or its own consumption shows up as a write enable that should not be there. Random mixes of requests on a few shared lines, together with directed same-cycle collisions, make both kinds of fault visible within a few cycles.

// File: rtl/llsc_rsv_pkg.sv
package llsc_rsv_pkg;
  typedef enum logic [1:0] {
    RSV_HOLD = 2'd0,
    RSV_SET  = 2'd1,
    RSV_DROP = 2'd2
  } rsv_act_e;
endpackage

// File: rtl/llsc_tag_eq.sv
module llsc_tag_eq #(
  parameter int unsigned TAG_W = 58
) (
  input  logic [TAG_W-1:0] a_i,
  input  logic [TAG_W-1:0] b_i,
  output logic             eq_o
);
  assign eq_o = (a_i == b_i);
endmodule

// File: rtl/llsc_rsv_slot.sv
module llsc_rsv_slot
  import llsc_rsv_pkg::*;
#(
  parameter int unsigned TAG_W = 58
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ll_i,
  input  logic [TAG_W-1:0] ll_tag_i,
  input  logic             sc_i,
  input  logic [TAG_W-1:0] sc_tag_i,
  input  logic             st_i,
  input  logic [TAG_W-1:0] st_tag_i,
  input  logic             clr_i,
  output logic             ok_o
);
  logic             vld_q;
  logic [TAG_W-1:0] tag_q;
  logic             rsv_sc_eq, sc_st_eq, ll_st_eq, rsv_st_eq;
  rsv_act_e         act;

  llsc_tag_eq #(.TAG_W(TAG_W)) u_eq_rsv_sc (.a_i(tag_q),    .b_i(sc_tag_i), .eq_o(rsv_sc_eq));
  llsc_tag_eq #(.TAG_W(TAG_W)) u_eq_sc_st  (.a_i(sc_tag_i), .b_i(st_tag_i), .eq_o(sc_st_eq));
  llsc_tag_eq #(.TAG_W(TAG_W)) u_eq_ll_st  (.a_i(ll_tag_i), .b_i(st_tag_i), .eq_o(ll_st_eq));
  llsc_tag_eq #(.TAG_W(TAG_W)) u_eq_rsv_st (.a_i(tag_q),    .b_i(st_tag_i), .eq_o(rsv_st_eq));

  // same-cycle store to the line or a clear beats the conditional
  assign ok_o = sc_i & vld_q & rsv_sc_eq & ~(st_i & sc_st_eq) & ~clr_i;

  always_comb begin
    act = RSV_HOLD;
    if (clr_i)                         act = RSV_DROP;
    else if (ll_i)                     act = (st_i & ll_st_eq) ? RSV_DROP : RSV_SET;
    else if (sc_i || (st_i && rsv_st_eq)) act = RSV_DROP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else begin
      unique case (act)
        RSV_SET: begin
          vld_q <= 1'b1;
          tag_q <= ll_tag_i;
        end
        RSV_DROP: vld_q <= 1'b0;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/llsc_rsv_tracker.sv
module llsc_rsv_tracker #(
  parameter int unsigned N_CPU      = 4,
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_CPU-1:0]              ll_req_i,
  input  logic [N_CPU-1:0][ADDR_W-1:0]  ll_addr_i,
  input  logic [N_CPU-1:0]              sc_req_i,
  input  logic [N_CPU-1:0][ADDR_W-1:0]  sc_addr_i,
  input  logic                          st_commit_i,
  input  logic [ADDR_W-1:0]             st_addr_i,
  input  logic [N_CPU-1:0]              rsv_clr_i,
  output logic [N_CPU-1:0]              sc_ok_o,
  output logic [N_CPU-1:0]              sc_wen_o
);
  localparam int unsigned LINE_LSB = $clog2(LINE_BYTES);
  localparam int unsigned TAG_W    = ADDR_W - LINE_LSB;

  logic [TAG_W-1:0] st_tag;
  logic [N_CPU-1:0] ok;
  logic [N_CPU-1:0][LINE_LSB-1:0] unused_ll_ofs, unused_sc_ofs;
  logic [LINE_LSB-1:0]            unused_st_ofs;

  assign st_tag        = st_addr_i[ADDR_W-1:LINE_LSB];
  assign unused_st_ofs = st_addr_i[LINE_LSB-1:0];

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    assign unused_ll_ofs[i] = ll_addr_i[i][LINE_LSB-1:0];
    assign unused_sc_ofs[i] = sc_addr_i[i][LINE_LSB-1:0];

    llsc_rsv_slot #(.TAG_W(TAG_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ll_i     (ll_req_i[i]),
      .ll_tag_i (ll_addr_i[i][ADDR_W-1:LINE_LSB]),
      .sc_i     (sc_req_i[i]),
      .sc_tag_i (sc_addr_i[i][ADDR_W-1:LINE_LSB]),
      .st_i     (st_commit_i),
      .st_tag_i (st_tag),
      .clr_i    (rsv_clr_i[i]),
      .ok_o     (ok[i])
    );
  end

  assign sc_ok_o  = ok;
  assign sc_wen_o = ok;
endmodule

// File: rtl/llsc_rsv_checker.sv
module llsc_rsv_checker #(
  parameter int unsigned N_CPU      = 4,
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned LINE_BYTES = 64
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [N_CPU-1:0]             ll_req_i,
  input logic [N_CPU-1:0]             sc_req_i,
  input logic [N_CPU-1:0][ADDR_W-1:0] sc_addr_i,
  input logic                         st_commit_i,
  input logic [ADDR_W-1:0]            st_addr_i,
  input logic [N_CPU-1:0]             rsv_clr_i,
  input logic [N_CPU-1:0]             sc_wen_o
);
  localparam int unsigned LSB = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0] unused_chk;
  assign unused_chk = sc_addr_i[0] ^ st_addr_i;

  for (genvar i = 0; i < N_CPU; i++) begin : g_chk
    AST_WEN_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sc_wen_o[i] |-> (sc_req_i[i] && !rsv_clr_i[i])); // R9
    AST_SAME_LINE_STORE_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sc_wen_o[i] && st_commit_i) |-> (sc_addr_i[i][ADDR_W-1:LSB] != st_addr_i[ADDR_W-1:LSB])); // R7
    AST_SC_CONSUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sc_req_i[i] && !ll_req_i[i]) |=> !sc_wen_o[i]); // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsv_clr_i[i] |=> !sc_wen_o[i]); // R8
    AST_STORE_BREAKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_commit_i && !ll_req_i[i]) |=>
        !(sc_wen_o[i] && (sc_addr_i[i][ADDR_W-1:LSB] == $past(st_addr_i[ADDR_W-1:LSB])))); // R6
  end
endmodule

bind llsc_rsv_tracker llsc_rsv_checker #(
  .N_CPU(N_CPU), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ll_req_i(ll_req_i), .sc_req_i(sc_req_i),
  .sc_addr_i(sc_addr_i), .st_commit_i(st_commit_i), .st_addr_i(st_addr_i),
  .rsv_clr_i(rsv_clr_i), .sc_wen_o(sc_wen_o)
);

// File: tb/llsc_rsv_tracker_bench.sv
`timescale 1ns/1ps
module llsc_rsv_tracker_bench;
  localparam int N  = 4;
  localparam int AW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]         ll_req = '0, sc_req = '0, clr = '0;
  logic [N-1:0][AW-1:0] ll_addr = '0, sc_addr = '0;
  logic                 st_v = 1'b0;
  logic [AW-1:0]        st_addr = '0;
  logic [N-1:0]         sc_ok, sc_wen;

  int total = 0, fails = 0;
  bit done = 1'b0;
  bit          m_vld [N];
  logic [57:0] m_tag [N];

  always #2 clk = ~clk;

  llsc_rsv_tracker #(.N_CPU(N), .ADDR_W(AW), .LINE_BYTES(64)) u_llsc_rsv_tracker (
    .clk_i(clk), .rst_ni(rst_n), .ll_req_i(ll_req), .ll_addr_i(ll_addr),
    .sc_req_i(sc_req), .sc_addr_i(sc_addr), .st_commit_i(st_v), .st_addr_i(st_addr),
    .rsv_clr_i(clr), .sc_ok_o(sc_ok), .sc_wen_o(sc_wen)
  );

  function automatic logic [57:0] tag_of(logic [63:0] a);
    return a[63:6];
  endfunction

  function automatic bit exp_ok(int i);
    return sc_req[i] && m_vld[i] && (m_tag[i] == tag_of(sc_addr[i]))
           && !(st_v && tag_of(st_addr) == tag_of(sc_addr[i])) && !clr[i];
  endfunction

  task automatic model_update();
    for (int i = 0; i < N; i++) begin
      if (clr[i]) m_vld[i] = 1'b0;
      else if (ll_req[i]) begin
        m_vld[i] = !(st_v && tag_of(st_addr) == tag_of(ll_addr[i]));
        m_tag[i] = tag_of(ll_addr[i]);
      end else if (sc_req[i] || (st_v && tag_of(st_addr) == m_tag[i])) m_vld[i] = 1'b0;
    end
  endtask

  // inputs already set at a negedge; check, clock, clear
  task automatic cyc(string rq);
    #1;
    for (int i = 0; i < N; i++) begin
      bit e;
      e = exp_ok(i);
      total++;
      if (sc_ok[i] !== e || sc_wen[i] !== e) begin
        fails++;
        $display("FAIL %s cpu%0d ok=%b wen=%b expected %b", rq, i, sc_ok[i], sc_wen[i], e);
      end
    end
    @(posedge clk);
    model_update();
    @(negedge clk);
    ll_req = '0; sc_req = '0; clr = '0; st_v = 1'b0;
  endtask

  localparam logic [63:0] A = 64'h8000_0000_0000_1000;
  localparam logic [63:0] B = 64'h0000_0000_0000_2040;
  localparam logic [63:0] C = 64'h0000_0000_0000_3000;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: nothing reserved after reset
    sc_req = 4'b1111; sc_addr = {A, A, B, C}; cyc("R1");
    // R2, R3: same line with other byte offset succeeds
    ll_req[0] = 1; ll_addr[0] = A; cyc("R2");
    sc_req[0] = 1; sc_addr[0] = A + 64'h3F; cyc("R2");
    // R3: next line fails
    ll_req[1] = 1; ll_addr[1] = B; cyc("R3");
    sc_req[1] = 1; sc_addr[1] = B + 64'h40; cyc("R3");
    // R4: consumed after success and after failure
    sc_req[0] = 1; sc_addr[0] = A; cyc("R4");
    ll_req[2] = 1; ll_addr[2] = C; cyc("R4");
    sc_req[2] = 1; sc_addr[2] = B; cyc("R4");
    sc_req[2] = 1; sc_addr[2] = C; cyc("R4");
    // R5: newer load-locked replaces
    ll_req[3] = 1; ll_addr[3] = A; cyc("R5");
    ll_req[3] = 1; ll_addr[3] = B; cyc("R5");
    sc_req[3] = 1; sc_addr[3] = A; cyc("R5");
    ll_req[3] = 1; ll_addr[3] = A; cyc("R5");
    ll_req[3] = 1; ll_addr[3] = B; cyc("R5");
    sc_req[3] = 1; sc_addr[3] = B; cyc("R5");
    // R6: store breaks all holders of the line only
    ll_req = 4'b0111; ll_addr = {C, B, A, A}; cyc("R6");
    st_v = 1; st_addr = A + 8; cyc("R6");
    sc_req = 4'b0111; sc_addr = {C, B, A, A}; cyc("R6");
    // R7: same-cycle store wins
    ll_req[0] = 1; ll_addr[0] = A; cyc("R7");
    sc_req[0] = 1; sc_addr[0] = A; st_v = 1; st_addr = A + 4; cyc("R7");
    // R8: clear is per CPU, beats load-locked and same-cycle conditional
    ll_req = 4'b0011; ll_addr = {C, C, A, A}; cyc("R8");
    clr[0] = 1; cyc("R8");
    sc_req = 4'b0011; sc_addr = {C, C, A, A}; cyc("R8");
    ll_req[2] = 1; ll_addr[2] = B; clr[2] = 1; cyc("R8");
    sc_req[2] = 1; sc_addr[2] = B; cyc("R8");
    ll_req[3] = 1; ll_addr[3] = C; cyc("R8");
    sc_req[3] = 1; sc_addr[3] = C; clr[3] = 1; cyc("R8");
    // R10: load-locked colliding with store; load-locked with conditional
    ll_req[0] = 1; ll_addr[0] = A; st_v = 1; st_addr = A; cyc("R10");
    sc_req[0] = 1; sc_addr[0] = A; cyc("R10");
    ll_req[1] = 1; ll_addr[1] = A; cyc("R10");
    ll_req[1] = 1; ll_addr[1] = B; sc_req[1] = 1; sc_addr[1] = A; cyc("R10");
    sc_req[1] = 1; sc_addr[1] = B; cyc("R10");

    // R9 and all others: random traffic on a few shared lines
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < N; i++) begin
        ll_req[i]  = ($urandom % 4) == 0;
        sc_req[i]  = ($urandom % 3) == 0;
        clr[i]     = ($urandom % 16) == 0;
        ll_addr[i] = {($urandom % 2) == 1, 51'd0, 6'(($urandom % 3)), 6'($urandom)};
        sc_addr[i] = {($urandom % 2) == 1, 51'd0, 6'(($urandom % 3)), 6'($urandom)};
      end
      st_v    = ($urandom % 3) == 0;
      st_addr = {($urandom % 2) == 1, 51'd0, 6'(($urandom % 3)), 6'($urandom)};
      cyc("R9");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule